// File: doc/BRIEF.md
# Host Port Status and Control Register

This block is the 32-bit status and control word of a single host port. Port hardware feeds it level inputs (attach, enable, over-current, power), a stream of link-state updates, speed and a set of completion pulses; software reads the assembled word and writes it through a one-cycle write port. Seven change flags latch individual events and stay set until software writes a 1 to their position. A summary output is high while any of them is set.

Software drives the port through the same word. Writing 1 to the reset bit, or to the warm-reset bit, starts a reset that is requested from the port hardware until a matching done pulse returns. A write moves the link-state field only when the strobe bit is set in the same word. Such a write also produces a one-cycle command towards the link. A detector watches the hardware link-state updates and raises the link-change flag on the transitions that matter to software, including the exits from Recovery that depend on the state the link held before it entered Recovery.

Top module: `port_ctl_reg`

## Requirements
- R1: Bits 0 (attached), 1 (enabled), 3 (over-current) and 9 (power) show the matching hardware inputs one clock after they change. Bits 2, 16, 28, 29 and 30 always read 0. After reset the word reads 0x000000A0, which is the link field holding RxDetect (5).
- R2: The link field is bits 8:5, encoded U0=0, U1=1, U2=2, U3=3, Disabled=4, RxDetect=5, Inactive=6, Polling=7, Recovery=8, HotReset=9, Compliance=10, Test=11 and Resume=15. A hardware update (`hw_link_valid`) loads it on the next edge and takes priority over a software write in the same cycle.
- R3: A software write changes bits 8:5 only when bit 16 of the same write is 1. Such a write pulses `link_cmd_valid` for one cycle, with the written value on `link_cmd_state`. Bit 16 is not stored.
- R4: The speed field, bits 13:10 (1 full, 2 low, 3 high, 4 super, 5 super-plus), reads 0 until the first reset completes. It then holds the value `hw_speed` had at the moment the reset completed, and changes only when a later reset completes.
- R5: The change flags are connect 17, enable 18, warm-reset 19, over-current 20, reset 21, link 22 and configure-error 23. Writing 1 to a flag clears it and writing 0 leaves it alone. If an event and a clearing write fall in the same cycle, the flag stays set.
- R6: The reset-change flag (bit 21) is set when bit 4 falls from 1 to 0.
- R7: On hardware link updates, bit 22 is set for the following transitions: U3 to Resume; U2, U3 or Resume to U0; Recovery to U0 when Recovery was entered from U3 or Resume; U0 to Disabled; and any other state to Inactive. No other transition sets it.
- R8: Writing 1 to bit 31 sets bits 31 and 4 and raises `warm_reset_req`. A `hw_warm_done` pulse clears both bits, sets bit 19 and clears cold-attach bit 24. `hw_reset_done` has no effect while a warm reset is running.
- R9: Writing 1 to bit 4 sets it and raises `port_reset_req` until `hw_reset_done`. `port_reset_req` and `warm_reset_req` are never high together.
- R10: The connect-change flag is set by any change of `hw_connect`, the enable-change flag by any change of `hw_enabled`, and the over-current-change flag by any change of `hw_overcurrent`. The configure-error flag is set by a `hw_cfg_err` pulse.
- R11: Bits 15:14 (indicator: 0 off, 1 amber, 2 green) and bits 27:25 (wake enables for connect, disconnect and over-current) hold what software last wrote. Bit 24 is set by a `hw_cold_attach` pulse.
- R12: `change_any` is high exactly when any of bits 23:17 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Software write, one cycle |
| wr_data | input | 32 | Word written by software |
| rd_data | output | 32 | Current status and control word |
| hw_connect | input | 1 | Device attached |
| hw_enabled | input | 1 | Port enabled |
| hw_overcurrent | input | 1 | Over-current present |
| hw_power | input | 1 | Port powered |
| hw_link_valid | input | 1 | Link state update strobe |
| hw_link_state | input | 4 | New link state |
| hw_speed | input | 4 | Speed reported by the port |
| hw_reset_done | input | 1 | Port reset finished, pulse |
| hw_warm_done | input | 1 | Warm reset finished, pulse |
| hw_cfg_err | input | 1 | Link partner configure failure, pulse |
| hw_cold_attach | input | 1 | Attach seen while asleep, pulse |
| port_reset_req | output | 1 | Port reset request to hardware |
| warm_reset_req | output | 1 | Warm reset request to hardware |
| link_cmd_valid | output | 1 | Software link-state command, one cycle |
| link_cmd_state | output | 4 | Commanded link state |
| change_any | output | 1 | Some change flag is set |

## Verification
The bench builds the block with its default parameters: 4-bit link and speed fields, with warm reset and cold attach both present. With a 4-bit link field, every ordered pair of the sixteen codes can be driven through the transition detector, and each pair is compared against a rule evaluated in the bench. A second sweep sends every start state through Recovery to U0, which covers the case that depends on what Recovery was entered from. Directed sequences then cover clear-versus-event collisions, the strobe gating, speed capture, and the interplay of the two kinds of reset.

// File: rtl/port_ctl_pkg.sv
package port_ctl_pkg;
   typedef enum logic [3:0] {
      LS_U0     = 4'd0,
      LS_U1     = 4'd1,
      LS_U2     = 4'd2,
      LS_U3     = 4'd3,
      LS_DIS    = 4'd4,
      LS_RXDET  = 4'd5,
      LS_INACT  = 4'd6,
      LS_POLL   = 4'd7,
      LS_RECOV  = 4'd8,
      LS_HOTRST = 4'd9,
      LS_COMPL  = 4'd10,
      LS_TEST   = 4'd11,
      LS_RESUME = 4'd15
   } link_st_e;

   // bit positions in the status word
   localparam int B_CONN = 0;
   localparam int B_EN   = 1;
   localparam int B_OC   = 3;
   localparam int B_RST  = 4;
   localparam int B_LS   = 5;
   localparam int B_PWR  = 9;
   localparam int B_SPD  = 10;
   localparam int B_IND  = 14;
   localparam int B_STRB = 16;
   localparam int B_CHG  = 17;
   localparam int B_COLD = 24;
   localparam int B_WAKE = 25;
   localparam int B_WARM = 31;

   // change flag index (offset from B_CHG)
   localparam int N_CHG  = 7;
   localparam int C_CONN = 0;
   localparam int C_EN   = 1;
   localparam int C_WARM = 2;
   localparam int C_OC   = 3;
   localparam int C_RST  = 4;
   localparam int C_LINK = 5;
   localparam int C_CFG  = 6;
endpackage

// File: rtl/port_chg_flag.sv
module port_chg_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr,
   output logic q
);
   // event has priority over the write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set_evt | (q & ~clr);
   end
endmodule

// File: rtl/port_ls_detect.sv
module port_ls_detect
   import port_ctl_pkg::*;
#(
   parameter int LS_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd,
   input  logic [LS_W-1:0] cur_ls,
   input  logic [LS_W-1:0] new_ls,
   output logic            plc_evt
);
   logic [LS_W-1:0] pre_rec_q;
   logic            wake_sig, to_u0, l1_err, to_inact, rec_ok;

   // state the link held just before it entered Recovery
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_rec_q <= LS_W'(LS_U0);
      else if (upd && new_ls == LS_W'(LS_RECOV) && cur_ls != LS_W'(LS_RECOV))
         pre_rec_q <= cur_ls;
   end

   always_comb begin
      rec_ok   = (pre_rec_q == LS_W'(LS_U3)) || (pre_rec_q == LS_W'(LS_RESUME));
      wake_sig = (cur_ls == LS_W'(LS_U3)) && (new_ls == LS_W'(LS_RESUME));
      to_u0    = (new_ls == LS_W'(LS_U0)) &&
                 ((cur_ls == LS_W'(LS_U2)) || (cur_ls == LS_W'(LS_U3)) ||
                  (cur_ls == LS_W'(LS_RESUME)) ||
                  ((cur_ls == LS_W'(LS_RECOV)) && rec_ok));
      l1_err   = (cur_ls == LS_W'(LS_U0)) && (new_ls == LS_W'(LS_DIS));
      to_inact = (new_ls == LS_W'(LS_INACT)) && (cur_ls != LS_W'(LS_INACT));
      plc_evt  = upd & (wake_sig | to_u0 | l1_err | to_inact);
   end
endmodule

// File: rtl/port_ctl_reg.sv
module port_ctl_reg
   import port_ctl_pkg::*;
#(
   parameter int        LS_W      = 4,
   parameter int        SPD_W     = 4,
   parameter bit        HAS_WARM  = 1'b1,
   parameter bit        HAS_COLD  = 1'b1,
   parameter logic [3:0] RESET_LS = 4'd5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [31:0]      wr_data,
   output logic [31:0]      rd_data,
   input  logic             hw_connect,
   input  logic             hw_enabled,
   input  logic             hw_overcurrent,
   input  logic             hw_power,
   input  logic             hw_link_valid,
   input  logic [LS_W-1:0]  hw_link_state,
   input  logic [SPD_W-1:0] hw_speed,
   input  logic             hw_reset_done,
   input  logic             hw_warm_done,
   input  logic             hw_cfg_err,
   input  logic             hw_cold_attach,
   output logic             port_reset_req,
   output logic             warm_reset_req,
   output logic             link_cmd_valid,
   output logic [LS_W-1:0]  link_cmd_state,
   output logic             change_any
);
   localparam int IND_W  = 2;
   localparam int WAKE_W = 3;

   if (LS_W != 4)  begin : g_bad_ls  $error("link field must be 4 bits");  end
   if (SPD_W != 4) begin : g_bad_spd $error("speed field must be 4 bits"); end

   logic              conn_q, en_q, oc_q, pwr_q;
   logic              rst_busy_q, rst_busy_d, rst_fall;
   logic              warm_busy_q, warm_start, warm_done;
   logic              cold_q;
   logic [LS_W-1:0]   ls_q;
   logic [SPD_W-1:0]  spd_q;
   logic [IND_W-1:0]  ind_q;
   logic [WAKE_W-1:0] wake_q;
   logic [N_CHG-1:0]  evt, clr, chg_q;
   logic              plc_evt, sw_ls_wr;

   assign sw_ls_wr = wr_en & wr_data[B_STRB];

   // ---------------- warm reset variant ----------------
   if (HAS_WARM) begin : g_warm
      assign warm_start = wr_en & wr_data[B_WARM];
      assign warm_done  = warm_busy_q & hw_warm_done;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          warm_busy_q <= 1'b0;
         else if (warm_start) warm_busy_q <= 1'b1;
         else if (warm_done)  warm_busy_q <= 1'b0;
      end
   end else begin : g_no_warm
      assign warm_start  = 1'b0;
      assign warm_done   = 1'b0;
      assign warm_busy_q = 1'b0;
   end

   // ---------------- cold attach variant ----------------
   if (HAS_COLD) begin : g_cold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cold_q <= 1'b0;
         else if (warm_done)      cold_q <= 1'b0;
         else if (hw_cold_attach) cold_q <= 1'b1;
      end
   end else begin : g_no_cold
      assign cold_q = 1'b0;
   end

   // ---------------- port reset tracking ----------------
   always_comb begin
      rst_busy_d = rst_busy_q;
      if (wr_en && (wr_data[B_RST] || warm_start)) rst_busy_d = 1'b1;
      else if (warm_done)                          rst_busy_d = 1'b0;
      else if (hw_reset_done && !warm_busy_q)      rst_busy_d = 1'b0;
   end
   assign rst_fall = rst_busy_q & ~rst_busy_d;

   // ---------------- status state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conn_q         <= 1'b0;
         en_q           <= 1'b0;
         oc_q           <= 1'b0;
         pwr_q          <= 1'b0;
         rst_busy_q     <= 1'b0;
         ls_q           <= LS_W'(RESET_LS);
         spd_q          <= '0;
         ind_q          <= '0;
         wake_q         <= '0;
         link_cmd_valid <= 1'b0;
         link_cmd_state <= '0;
      end else begin
         conn_q         <= hw_connect;
         en_q           <= hw_enabled;
         oc_q           <= hw_overcurrent;
         pwr_q          <= hw_power;
         rst_busy_q     <= rst_busy_d;
         link_cmd_valid <= sw_ls_wr;
         if (sw_ls_wr)       link_cmd_state <= wr_data[B_LS +: LS_W];
         if (hw_link_valid)  ls_q <= hw_link_state;
         else if (sw_ls_wr)  ls_q <= wr_data[B_LS +: LS_W];
         if (rst_fall)       spd_q <= hw_speed;
         if (wr_en) begin
            ind_q  <= wr_data[B_IND  +: IND_W];
            wake_q <= wr_data[B_WAKE +: WAKE_W];
         end
      end
   end

   // ---------------- link transition detector ----------------
   port_ls_detect #(.LS_W(LS_W)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (hw_link_valid),
      .cur_ls  (ls_q),
      .new_ls  (hw_link_state),
      .plc_evt (plc_evt)
   );

   // ---------------- change flags ----------------
   always_comb begin
      evt         = '0;
      evt[C_CONN] = hw_connect ^ conn_q;
      evt[C_EN]   = hw_enabled ^ en_q;
      evt[C_WARM] = warm_done;
      evt[C_OC]   = hw_overcurrent ^ oc_q;
      evt[C_RST]  = rst_fall;
      evt[C_LINK] = plc_evt;
      evt[C_CFG]  = hw_cfg_err;
   end

   for (genvar i = 0; i < N_CHG; i++) begin : g_chg
      assign clr[i] = wr_en & wr_data[B_CHG + i];
      port_chg_flag u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (evt[i]),
         .clr     (clr[i]),
         .q       (chg_q[i])
      );
   end

   // ---------------- read word and outputs ----------------
   always_comb begin
      rd_data                   = '0;
      rd_data[B_CONN]           = conn_q;
      rd_data[B_EN]             = en_q;
      rd_data[B_OC]             = oc_q;
      rd_data[B_RST]            = rst_busy_q;
      rd_data[B_LS +: LS_W]     = ls_q;
      rd_data[B_PWR]            = pwr_q;
      rd_data[B_SPD +: SPD_W]   = spd_q;
      rd_data[B_IND +: IND_W]   = ind_q;
      rd_data[B_CHG +: N_CHG]   = chg_q;
      rd_data[B_COLD]           = cold_q;
      rd_data[B_WAKE +: WAKE_W] = wake_q;
      rd_data[B_WARM]           = warm_busy_q;
   end

   assign change_any     = |chg_q;
   assign port_reset_req = rst_busy_q & ~warm_busy_q;
   assign warm_reset_req = warm_busy_q;
endmodule

// File: rtl/port_ctl_reg_chk.sv
module port_ctl_reg_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [31:0] wr_data,
   input logic        hw_link_valid,
   input logic [31:0] rd_data,
   input logic        change_any,
   input logic        port_reset_req,
   input logic        warm_reset_req
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[2] == 1'b0 && rd_data[30:28] == 3'b000);  // R1

   AST_STRB_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[16] == 1'b0);  // R3

   AST_LS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[16] && !hw_link_valid) |=> $stable(rd_data[8:5]));  // R3

   AST_SPD_AT_RST_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data[13:10]) |-> $fell(rd_data[4]));  // R4

   AST_RC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[4]) |-> rd_data[21]);  // R6

   AST_WRC_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[31]) |-> rd_data[19]);  // R8

   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_reset_req && warm_reset_req));  // R9

   AST_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
      change_any == (rd_data[23:17] != 7'd0));  // R12
endmodule

bind port_ctl_reg port_ctl_reg_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .wr_data        (wr_data),
   .hw_link_valid  (hw_link_valid),
   .rd_data        (rd_data),
   .change_any     (change_any),
   .port_reset_req (port_reset_req),
   .warm_reset_req (warm_reset_req)
);

// File: tb/tb_port_ctl_reg.sv
module tb_port_ctl_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        hw_connect = 0, hw_enabled = 0, hw_overcurrent = 0, hw_power = 0;
   logic        hw_link_valid = 0;
   logic [3:0]  hw_link_state = '0;
   logic [3:0]  hw_speed = '0;
   logic        hw_reset_done = 0, hw_warm_done = 0, hw_cfg_err = 0, hw_cold_attach = 0;
   logic        port_reset_req, warm_reset_req, link_cmd_valid, change_any;
   logic [3:0]  link_cmd_state;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   port_ctl_reg dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .hw_connect(hw_connect), .hw_enabled(hw_enabled), .hw_overcurrent(hw_overcurrent),
      .hw_power(hw_power), .hw_link_valid(hw_link_valid), .hw_link_state(hw_link_state),
      .hw_speed(hw_speed), .hw_reset_done(hw_reset_done), .hw_warm_done(hw_warm_done),
      .hw_cfg_err(hw_cfg_err), .hw_cold_attach(hw_cold_attach),
      .port_reset_req(port_reset_req), .warm_reset_req(warm_reset_req),
      .link_cmd_valid(link_cmd_valid), .link_cmd_state(link_cmd_state),
      .change_any(change_any)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic hw_ls(input logic [3:0] v);
      @(negedge clk); hw_link_valid = 1'b1; hw_link_state = v;
      @(negedge clk); hw_link_valid = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   // link-change rule for a direct transition, from the requirement text
   function automatic bit exp_plc(input int a, input int b);
      return (a == 3 && b == 15) ||
             (b == 0 && (a == 2 || a == 3 || a == 15)) ||
             (a == 0 && b == 4) ||
             (b == 6 && a != 6);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R1 reset value
      chk("R1 reset word", rd_data, 32'h0000_00A0);
      chk("R12 reset summary", {31'd0, change_any}, 32'd0);
      chk("R9 reset reqs", {30'd0, port_reset_req, warm_reset_req}, 32'd0);

      // R7 / R2: every ordered pair of link codes
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            hw_ls(4'd1);
            hw_ls(4'(a));
            wr(32'h0040_0000);
            hw_ls(4'(b));
            chk($sformatf("R7 pair %0d->%0d", a, b), {31'd0, rd_data[22]},
                {31'd0, exp_plc(a, b)});
            chk("R2 field load", {28'd0, rd_data[8:5]}, 32'(b));
         end
      end
      // R7: through Recovery into U0
      for (int a = 0; a < 16; a++) begin
         if (a == 8) continue;
         hw_ls(4'(a));
         hw_ls(4'd8);
         wr(32'h0040_0000);
         hw_ls(4'd0);
         chk($sformatf("R7 %0d->Rec->U0", a), {31'd0, rd_data[22]},
             {31'd0, (a == 3 || a == 15)});
      end
      wr(32'h00FE_0000);

      // R1 / R10 mirrors and change flags
      @(negedge clk); hw_connect = 1; hw_enabled = 1; hw_overcurrent = 1; hw_power = 1;
      idle();
      chk("R1 mirrors", rd_data & 32'h0000_020B, 32'h0000_020B);
      chk("R10 conn/en/oc flags", {25'd0, rd_data[23:17]}, 32'h0B);
      chk("R12 summary set", {31'd0, change_any}, 32'd1);
      wr(32'h00FE_0000);
      chk("R5 clear all", {25'd0, rd_data[23:17]}, 32'd0);
      chk("R12 summary clear", {31'd0, change_any}, 32'd0);
      // R5 event wins over clear
      @(negedge clk); hw_connect = 0; wr_en = 1; wr_data = 32'h0002_0000;
      @(negedge clk); wr_en = 0; wr_data = '0;
      chk("R5 event wins", {30'd0, rd_data[17], rd_data[0]}, 32'b10);
      wr(32'h0000_0000);
      chk("R5 write 0 keeps", {31'd0, rd_data[17]}, 32'd1);
      wr(32'h0002_0000);
      chk("R5 w1c", {25'd0, rd_data[23:17]}, 32'd0);
      // R10 configure error
      @(negedge clk); hw_cfg_err = 1;
      @(negedge clk); hw_cfg_err = 0;
      chk("R10 cfg err", {25'd0, rd_data[23:17]}, 32'h40);
      chk("R12 summary cfg", {31'd0, change_any}, 32'd1);
      wr(32'h0080_0000);

      // R3 strobe gating
      hw_ls(4'd0);
      wr(32'h0000_0060);
      chk("R3 no strobe", {28'd0, rd_data[8:5]}, 32'd0);
      chk("R3 no cmd", {31'd0, link_cmd_valid}, 32'd0);
      wr(32'h0001_0060);
      chk("R3 strobe write", {28'd0, rd_data[8:5]}, 32'd3);
      chk("R3 strobe cmd", {27'd0, link_cmd_valid, link_cmd_state}, 32'h13);
      chk("R3 bit16 not stored", {31'd0, rd_data[16]}, 32'd0);
      idle();
      chk("R3 cmd one cycle", {31'd0, link_cmd_valid}, 32'd0);

      // R11 indicator and wake
      wr(32'h0A00_8000);
      chk("R11 ind/wake", {16'd0, 4'd0, rd_data[27:25], 7'd0, rd_data[15:14]},
          {16'd0, 4'd0, 3'b101, 7'd0, 2'b10});

      // R9 / R4 / R6 port reset
      chk("R4 speed before reset", {28'd0, rd_data[13:10]}, 32'd0);
      hw_speed = 4'd4;
      wr(32'h0000_0010);
      chk("R9 reset busy", {30'd0, rd_data[4], port_reset_req}, 32'b11);
      chk("R4 speed during reset", {28'd0, rd_data[13:10]}, 32'd0);
      @(negedge clk); hw_reset_done = 1;
      @(negedge clk); hw_reset_done = 0;
      chk("R9 reset done", {30'd0, rd_data[4], port_reset_req}, 32'd0);
      chk("R6 reset change", {31'd0, rd_data[21]}, 32'd1);
      chk("R4 speed captured", {28'd0, rd_data[13:10]}, 32'd4);
      hw_speed = 4'd1;
      idle(); idle();
      chk("R4 speed held", {28'd0, rd_data[13:10]}, 32'd4);
      wr(32'h0020_0000);

      // R8 warm reset and cold attach
      @(negedge clk); hw_cold_attach = 1;
      @(negedge clk); hw_cold_attach = 0;
      chk("R11 cold attach", {31'd0, rd_data[24]}, 32'd1);
      wr(32'h8000_0000);
      chk("R8 warm start", {28'd0, rd_data[31], rd_data[4], warm_reset_req, port_reset_req},
          32'b1110);
      @(negedge clk); hw_reset_done = 1;
      @(negedge clk); hw_reset_done = 0;
      chk("R8 reset_done ignored", {30'd0, rd_data[31], rd_data[4]}, 32'b11);
      @(negedge clk); hw_warm_done = 1;
      @(negedge clk); hw_warm_done = 0;
      chk("R8 warm done", {27'd0, rd_data[31], rd_data[4], rd_data[24], rd_data[19], rd_data[21]},
          32'b00011);
      chk("R8 speed at warm end", {28'd0, rd_data[13:10]}, 32'd1);
      chk("R8 warm req low", {31'd0, warm_reset_req}, 32'd0);

      finish_run();
   end
endmodule